// File: doc/BRIEF.md
# Fast-Clear Word Memory

This block is a single-port synchronous word memory that can be wiped in a fixed, short time however deep it is. The data array itself is never rewritten on a wipe. Instead, each word carries a one-bit valid flag, and a read returns zeros for any word whose flag is down. A wipe lowers every flag. A write raises the flag of the word it stores.

The flags are held in narrow 16-entry memory slices. Each slice covers a group of word addresses. A wipe sweeps the entry index from 0 to 15 and clears that entry in every slice in parallel, so the wipe costs 16 cycles at any depth.

Reset starts the same sweep. While a sweep runs, `busy` is high and reads and writes are dropped. Reads have one cycle of latency. `rd_valid` marks the cycle that carries a read result.

Top module: `fcm_top`

## Requirements
- R1: While `rst_n` is low, `busy` is 1, `rd_valid` is 0 and `rd_data` is 0. After reset is released, `busy` stays high for exactly 16 sampled cycles, and after that every unwritten word reads as zero.
- R2: A write stores `wr_data` at `addr`. A later read of that address returns the stored word.
- R3: A read of a word that has not been written since the last wipe returns all zeros with `rd_valid` 1.
- R4: A pulse on `clr_req` makes every word read as zero once the sweep ends. A word written after the wipe reads back its new value.
- R5: A wipe holds `busy` high for exactly 16 cycles after the edge that samples `clr_req`.
- R6: Reads and writes presented while `busy` or `clr_req` is high are ignored. Such a read gives no `rd_valid`. Such a write leaves the word reading zero after the sweep, even when it targets an entry the sweep has already passed.
- R7: A `clr_req` that arrives during a sweep restarts it at entry 0. `busy` then stays high for 16 cycles after the last request.
- R8: Read results appear exactly one cycle after `rd_en` is sampled. `rd_valid` is high only in that cycle.
- R9: A write and a read of the same address in one cycle return the word's previous contents and previous flag (read-before-write).
- R10: The low 4 address bits select the entry within a slice and the upper bits select the slice. A write validates only its own word: address 0x15 (same entry, next slice) and address 0x04 (same slice, next entry) stay zero after a write to 0x05.
- R11: Back-to-back `clr_req` cycles leave the memory wiped, with one 16-cycle busy window after the last request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_req | input | 1 | Request to wipe the whole memory |
| busy | output | 1 | Sweep in progress; accesses are dropped |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (8) | Word address for read and write |
| wr_data | input | DATA_W (32) | Word to write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W (32) | Read word, zero if the word's flag is down |
| rd_valid | output | 1 | Read result present this cycle |

## Verification
On every cycle, the assertions check the following:
- A request resets the sweep index to 0 (R7).
- The sweep finishes after its last entry (R5).
- A sweep write never coincides with a flag set.
- No read result follows a busy cycle (R6).
- Nonzero read data only appears with `rd_valid`.

Some behaviour only the bench scenarios can show, because it depends on data flowing across many cycles:
- Whether a stored word returns intact.
- Whether neighbouring addresses stay unvalidated.
- Whether writes dropped late in a sweep leave no trace.
- Whether read-before-write returns old data and old flags.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  typedef enum logic {
    SWP_IDLE = 1'b0,
    SWP_RUN  = 1'b1
  } swp_state_t;
endpackage

// File: rtl/fcm_sweep_ctrl.sv
module fcm_sweep_ctrl
  import fcm_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int ENT_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_req,
  output logic             sweeping,
  output logic [ENT_W-1:0] sweep_idx
);
  localparam logic [ENT_W-1:0] LAST_IDX = ENT_W'(ENTRIES - 1);

  swp_state_t       state_q, state_d;
  logic [ENT_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (clr_req) begin
      state_d = SWP_RUN;
      idx_d   = '0;
    end else if (state_q == SWP_RUN) begin
      if (idx_q == LAST_IDX) begin
        state_d = SWP_IDLE;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SWP_RUN;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign sweeping  = (state_q == SWP_RUN);
  assign sweep_idx = idx_q;

  // R7
  restart_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (sweeping && sweep_idx == '0));

  // R5
  sweep_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && sweep_idx == LAST_IDX && !clr_req) |=> !sweeping);
endmodule

// File: rtl/fcm_flag_bank.sv
module fcm_flag_bank #(
  parameter int DEPTH   = 256,
  parameter int ENTRIES = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int ENT_W  = $clog2(ENTRIES),
  localparam int NSLICE = DEPTH / ENTRIES,
  localparam int SLC_W  = ADDR_W - ENT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sweep_we,
  input  logic [ENT_W-1:0]  sweep_idx,
  input  logic              set_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  output logic              flag_q
);
  logic [ENT_W-1:0]  ent;
  logic [SLC_W-1:0]  slc;
  logic [NSLICE-1:0] set_en;
  logic [NSLICE-1:0] slice_bit;
  logic              flag_d;

  assign ent = addr[ENT_W-1:0];
  assign slc = addr[ADDR_W-1:ENT_W];

  always_comb begin
    set_en = '0;
    if (set_req) set_en[slc] = 1'b1;
  end

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    logic [ENTRIES-1:0] bits_q;
    always_ff @(posedge clk) begin
      if (sweep_we)       bits_q[sweep_idx] <= 1'b0;
      else if (set_en[g]) bits_q[ent]       <= 1'b1;
    end
    assign slice_bit[g] = bits_q[ent];
  end

  always_comb begin
    flag_d = flag_q;
    if (rd_req) flag_d = slice_bit[slc];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // R6
  no_set_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sweep_we && (|set_en)));
endmodule

// File: rtl/fcm_data_array.sv
module fcm_data_array #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata     <= mem[addr];
  end
endmodule

// File: rtl/fcm_top.sv
module fcm_top #(
  parameter int DEPTH   = 256,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int ENT_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_req,
  output logic              busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic             sweeping;
  logic [ENT_W-1:0] sweep_idx;
  logic             acc_ok, wr_ok, rd_ok;
  logic             flag_q;
  logic [DATA_W-1:0] raw_q;
  logic             rv_q, rv_d;

  assign acc_ok = !sweeping && !clr_req;
  assign wr_ok  = wr_en && acc_ok;
  assign rd_ok  = rd_en && acc_ok;

  fcm_sweep_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req),
    .sweeping(sweeping), .sweep_idx(sweep_idx)
  );

  fcm_flag_bank #(.DEPTH(DEPTH), .ENTRIES(ENTRIES)) i_flags (
    .clk(clk), .rst_n(rst_n), .sweep_we(sweeping), .sweep_idx(sweep_idx),
    .set_req(wr_ok), .rd_req(rd_ok), .addr(addr), .flag_q(flag_q)
  );

  fcm_data_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_data (
    .clk(clk), .we(wr_ok), .re(rd_ok), .addr(addr),
    .wdata(wr_data), .rdata(raw_q)
  );

  assign rv_d = rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= rv_d;
  end

  assign busy     = sweeping;
  assign rd_valid = rv_q;
  assign rd_data  = (rv_q && flag_q) ? raw_q : '0;

  // R6
  no_result_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !rd_valid);

  // R3
  data_only_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != '0) |-> rd_valid);
endmodule

// File: tb/test_fcm_top.sv
`timescale 1ns/1ps
module test_fcm_top;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr_req, wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data;
  logic          busy, rd_valid;
  logic [DW-1:0] rd_data;

  int applied = 0;
  int misses  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  fcm_top i_fcm_top (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .busy(busy),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // op: 0 write, 1 read-and-compare, 2 wipe
  localparam logic [73:0] VEC [14] = '{
    {2'd1, 8'h05, 32'h0,         32'h0},
    {2'd0, 8'h05, 32'hA5A50001, 32'h0},
    {2'd1, 8'h05, 32'h0,         32'hA5A50001},
    {2'd1, 8'h15, 32'h0,         32'h0},
    {2'd1, 8'h04, 32'h0,         32'h0},
    {2'd0, 8'hFF, 32'hDEADBEEF, 32'h0},
    {2'd1, 8'hFF, 32'h0,         32'hDEADBEEF},
    {2'd0, 8'h00, 32'h12345678, 32'h0},
    {2'd1, 8'h00, 32'h0,         32'h12345678},
    {2'd2, 8'h00, 32'h0,         32'h0},
    {2'd1, 8'hFF, 32'h0,         32'h0},
    {2'd1, 8'h05, 32'h0,         32'h0},
    {2'd0, 8'h05, 32'hCAFE0005, 32'h0},
    {2'd1, 8'h05, 32'h0,         32'hCAFE0005}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    applied++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    chk({req, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
    chk({req, " rd_data"}, rd_data, exp);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      tick();
    end
  endtask

  task automatic do_clr(output int n);
    clr_req = 1'b1;
    tick();
    clr_req = 1'b0;
    busy_len(n);
  endtask

  initial begin
    #100000;
    if (!done) begin
      misses++;
      applied++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; clr_req = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy in reset", {31'b0, busy}, 32'd1);
    chk("R1 rd_valid in reset", {31'b0, rd_valid}, 32'd0);
    chk("R1 rd_data in reset", rd_data, 32'd0);
    rst_n = 1'b1;
    tick();
    busy_len(n);
    chk("R1 busy after reset", n, 32'd15);

    // table walk (R2 R3 R4 R10)
    for (int i = 0; i < 14; i++) begin
      case (VEC[i][73:72])
        2'd0: do_wr(VEC[i][71:64], VEC[i][63:32]);
        2'd1: do_rd("R2/R3/R4/R10 table", VEC[i][71:64], VEC[i][31:0]);
        default: do_clr(n);
      endcase
    end

    // R5 wipe length
    do_clr(n);
    chk("R5 busy length", n, 32'd16);

    // R6 accesses during sweep dropped
    clr_req = 1'b1; tick(); clr_req = 1'b0;
    repeat (9) tick();
    wr_en = 1'b1; rd_en = 1'b1; addr = 8'h30; wr_data = 32'h11111111;
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R6 no rd_valid while busy", {31'b0, rd_valid}, 32'd0);
    busy_len(n);
    do_rd("R6 dropped write", 8'h30, 32'h0);

    // R7 restart
    do_wr(8'h22, 32'h2222);
    clr_req = 1'b1; tick(); clr_req = 1'b0;
    repeat (5) tick();
    do_clr(n);
    chk("R7 restart busy length", n, 32'd16);
    do_rd("R7 wiped", 8'h22, 32'h0);

    // R11 back-to-back
    do_wr(8'h33, 32'h3333);
    clr_req = 1'b1; tick(); tick(); clr_req = 1'b0;
    busy_len(n);
    chk("R11 busy after double request", n, 32'd16);
    do_rd("R11 wiped", 8'h33, 32'h0);

    // R8 latency
    do_wr(8'h44, 32'h4444);
    do_rd("R8 one-cycle read", 8'h44, 32'h4444);
    tick();
    chk("R8 rd_valid single cycle", {31'b0, rd_valid}, 32'd0);

    // R9 read-before-write, old data
    do_wr(8'h40, 32'h1);
    wr_en = 1'b1; rd_en = 1'b1; addr = 8'h40; wr_data = 32'h2;
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 old data", rd_data, 32'h1);
    do_rd("R9 new data", 8'h40, 32'h2);

    // R9 read-before-write, old flag
    wr_en = 1'b1; rd_en = 1'b1; addr = 8'h41; wr_data = 32'h9;
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 old flag zero", rd_data, 32'h0);
    do_rd("R9 flag now set", 8'h41, 32'h9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end
endmodule